// File: doc/BRIEF.md
# Presettable Binary Up Counter with Terminal-Count Reload

This block is a synchronous binary up counter. It is eight bits wide by default. It can be preset from a parallel bus, and its count enable and parallel-load enable are both active low. An active-low terminal-count flag is decoded from the registered count. It goes low in the same cycle in which the count reaches all-ones. Because of this, the flag can drive the count enable of a following counter when stages are cascaded.

When the reload control is high, the flag is fed back internally. A counter that is counting at all-ones then loads the preset value at the next edge instead of wrapping. The block therefore divides its clock by 2^WIDTH minus the preset value.

A master reset input clears the count at once, without waiting for a clock edge. It takes precedence over every other input.

Top module: `pcnt_top`

## Requirements
- R1: With `load_n` = 1 and `cnt_en_n` = 0, each rising clock edge increments `q` by one. Feedback reload (R6) is the only exception.
- R2: With `load_n` = 0, a rising edge copies `preset` into `q`. This happens whatever the values of `cnt_en_n` and `tc_reload`.
- R3: With `load_n` = 1 and `cnt_en_n` = 1, `q` keeps its value across rising edges. This also holds at all-ones while `tc_reload` = 1.
- R4: `tc_n` is 0 exactly when `q` is all-ones and 1 otherwise. It follows `q` in the same cycle, with no extra register stage.
- R5: With `tc_reload` = 0 and counting enabled, the count goes from all-ones to zero.
- R6: With `tc_reload` = 1, `load_n` = 1 and `cnt_en_n` = 0, an edge taken while `tc_n` = 0 loads `preset`. With preset value P, `q` then returns to P every 2^WIDTH − P cycles: every 256 − P cycles at the default width.
- R7: `mrst` = 1 forces `q` to zero and `tc_n` to 1 without waiting for a clock edge. Both stay there across clock edges, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter acts on the rising edge |
| mrst | input | 1 | Asynchronous master reset, active high |
| preset | input | WIDTH | Parallel preset value |
| load_n | input | 1 | Parallel-load enable, active low |
| cnt_en_n | input | 1 | Count enable, active low |
| tc_reload | input | 1 | When high, the counter reloads `preset` at all-ones |
| q | output | WIDTH | Counter value |
| tc_n | output | 1 | Terminal count, low while `q` is all-ones |

## Verification
The bench builds the counter at the default `WIDTH` of 8. At that width the whole 256-state cycle fits easily in a run, including the wrap from all-ones to zero. Every division ratio from 1 (preset 255) to 256 (preset 0) is within reach, and the bench measures ratios at both ends of that range and at one value between them. Random sequences of load, count and hold, mixed with reload on and off, reach all-ones under each combination of controls. They are checked against a bench reference model of the counter.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;

    // Operation chosen for the next clock edge
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_INC  = 2'd1,
        OP_LOAD = 2'd2
    } pcnt_op_e;

    // Decoded control inputs, all active high
    typedef struct packed {
        logic load;
        logic count;
        logic reload;
        logic at_term;
    } pcnt_ctl_t;

    // Priority: parallel load, then hold, then feedback reload, then increment
    function automatic pcnt_op_e pick_op(input pcnt_ctl_t c);
        pcnt_op_e op;
        if (c.load)
            op = OP_LOAD;
        else if (!c.count)
            op = OP_HOLD;
        else if (c.reload && c.at_term)
            op = OP_LOAD;
        else
            op = OP_INC;
        return op;
    endfunction

endpackage

// File: rtl/pcnt_term.sv
module pcnt_term #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] q,
    output logic             at_term,
    output logic             tc_n
);
    // All-ones detect on the registered count, no extra stage
    always_comb begin
        at_term = &q;
        tc_n    = ~at_term;
    end
endmodule

// File: rtl/pcnt_ctrl.sv
module pcnt_ctrl
    import pcnt_pkg::*;
(
    input  logic     load_n,
    input  logic     cnt_en_n,
    input  logic     tc_reload,
    input  logic     at_term,
    output pcnt_op_e op
);
    pcnt_ctl_t ctl;

    always_comb begin
        ctl.load    = ~load_n;
        ctl.count   = ~cnt_en_n;
        ctl.reload  = tc_reload;
        ctl.at_term = at_term;
        op          = pick_op(ctl);
    end
endmodule

// File: rtl/pcnt_reg.sv
module pcnt_reg
    import pcnt_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             mrst,
    input  pcnt_op_e         op,
    input  logic [WIDTH-1:0] preset,
    output logic [WIDTH-1:0] q
);
    localparam logic [WIDTH-1:0] ZERO = '0;
    localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [WIDTH-1:0] q_next;

    always_comb begin
        unique case (op)
            OP_LOAD: q_next = preset;
            OP_INC:  q_next = q + ONE;
            default: q_next = q;
        endcase
    end

    always_ff @(posedge clk or posedge mrst) begin
        if (mrst)
            q <= ZERO;
        else
            q <= q_next;
    end
endmodule

// File: rtl/pcnt_top.sv
module pcnt_top
    import pcnt_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             mrst,
    input  logic [WIDTH-1:0] preset,
    input  logic             load_n,
    input  logic             cnt_en_n,
    input  logic             tc_reload,
    output logic [WIDTH-1:0] q,
    output logic             tc_n
);
    pcnt_op_e op;
    logic     at_term;

    pcnt_term #(.WIDTH(WIDTH)) u_term (
        .q       (q),
        .at_term (at_term),
        .tc_n    (tc_n)
    );

    pcnt_ctrl u_ctrl (
        .load_n    (load_n),
        .cnt_en_n  (cnt_en_n),
        .tc_reload (tc_reload),
        .at_term   (at_term),
        .op        (op)
    );

    pcnt_reg #(.WIDTH(WIDTH)) u_reg (
        .clk    (clk),
        .mrst   (mrst),
        .op     (op),
        .preset (preset),
        .q      (q)
    );
endmodule

// File: rtl/pcnt_chk.sv
module pcnt_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             mrst,
    input logic [WIDTH-1:0] preset,
    input logic             load_n,
    input logic             cnt_en_n,
    input logic             tc_reload,
    input logic [WIDTH-1:0] q,
    input logic             tc_n
);
    localparam logic [WIDTH-1:0] ALL1 = '1;
    localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

    // R2: parallel load wins over everything except reset
    a_r2_load_prio: assert property (@(posedge clk) disable iff (mrst)
        !load_n |=> q == $past(preset));

    // R3: hold keeps the count
    a_r3_hold: assert property (@(posedge clk) disable iff (mrst)
        (load_n && cnt_en_n) |=> $stable(q));

    // R1 and R5: increment, wrapping when reload is off
    a_r1_increment: assert property (@(posedge clk) disable iff (mrst)
        (load_n && !cnt_en_n && !(tc_reload && !tc_n)) |=> q == $past(q) + ONE);

    // R6: feedback reload at terminal count
    a_r6_reload: assert property (@(posedge clk) disable iff (mrst)
        (load_n && !cnt_en_n && tc_reload && !tc_n) |=> q == $past(preset));

    // R7: reset holds the outputs cleared at every edge
    a_r7_reset: assert property (@(posedge clk)
        mrst |-> (q == '0 && tc_n));

    // R4: terminal flag tracks the count combinationally
    always_comb begin
        if (!mrst)
            a_r4_tc_flag: assert (tc_n == (q != ALL1));
    end
endmodule

bind pcnt_top pcnt_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .mrst      (mrst),
    .preset    (preset),
    .load_n    (load_n),
    .cnt_en_n  (cnt_en_n),
    .tc_reload (tc_reload),
    .q         (q),
    .tc_n      (tc_n)
);

// File: tb/sim_pcnt_top.sv
`timescale 1ns/1ps
module sim_pcnt_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         mrst;
    logic [W-1:0] preset;
    logic         load_n, cnt_en_n, tc_reload;
    logic [W-1:0] q;
    logic         tc_n;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] exp_q;

    pcnt_top #(.WIDTH(W)) u0 (
        .clk(clk), .mrst(mrst), .preset(preset), .load_n(load_n),
        .cnt_en_n(cnt_en_n), .tc_reload(tc_reload), .q(q), .tc_n(tc_n)
    );

    always #5 clk = ~clk;

    // Reference model drawn from the requirements
    function automatic logic [W-1:0] model_next(input logic [W-1:0] cur,
        input logic [W-1:0] p, input logic ld_n, input logic ce_n, input logic tcl);
        if (!ld_n) return p;                       // R2
        if (ce_n) return cur;                      // R3
        if (tcl && cur == '1) return p;            // R6
        return cur + 1'b1;                         // R1, R5
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive on the falling edge, sample 1 ns after the rising edge
    task automatic tick(input logic [W-1:0] p, input logic ld_n, input logic ce_n,
                        input logic tcl, input string req);
        @(negedge clk);
        preset = p; load_n = ld_n; cnt_en_n = ce_n; tc_reload = tcl;
        @(posedge clk);
        #1;
        exp_q = model_next(exp_q, p, ld_n, ce_n, tcl);
        check(req, q, exp_q);
        check("R4", tc_n, (exp_q == '1) ? 0 : 1);
    endtask

    task automatic divide_test(input logic [W-1:0] p);
        int n = 0;
        tick(p, 1'b0, 1'b1, 1'b1, "R2");
        for (int i = 0; i < 300; i++) begin
            tick(p, 1'b1, 1'b0, 1'b1, "R6");
            n++;
            if (q == p) break;
        end
        check("R6 period", n, 256 - int'(p));
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240));
        mrst = 1'b1; preset = '0; load_n = 1'b1; cnt_en_n = 1'b1; tc_reload = 1'b0;
        exp_q = '0;
        repeat (2) @(posedge clk);
        #1;
        check("R7 reset q", q, 0);
        check("R7 reset tc_n", tc_n, 1);
        @(negedge clk);
        mrst = 1'b0;

        // R2: load takes priority even with count enabled and reload high
        tick(8'h5A, 1'b0, 1'b0, 1'b1, "R2");
        tick(8'h33, 1'b0, 1'b1, 1'b0, "R2");
        // R1: counting
        for (int i = 0; i < 5; i++) tick(8'h00, 1'b1, 1'b0, 1'b0, "R1");
        // R3: hold
        for (int i = 0; i < 3; i++) tick(8'h99, 1'b1, 1'b1, 1'b1, "R3");
        // R5: wrap with reload off; R4 sees all-ones in the cycle it appears
        tick(8'hFE, 1'b0, 1'b1, 1'b0, "R2");
        tick(8'h10, 1'b1, 1'b0, 1'b0, "R4");
        tick(8'h10, 1'b1, 1'b0, 1'b0, "R5");
        check("R5 wrap", q, 0);
        // R3: hold at all-ones with reload on does not reload
        tick(8'hFF, 1'b0, 1'b1, 1'b0, "R2");
        tick(8'h21, 1'b1, 1'b1, 1'b1, "R3");
        check("R3 hold at terminal", q, 8'hFF);
        // R6: division ratios
        divide_test(8'h00);
        divide_test(8'hFF);
        divide_test(8'hC8);

        // R7: asynchronous reset between edges, held across an edge
        @(negedge clk);
        preset = 8'hAA; load_n = 1'b0; cnt_en_n = 1'b0; tc_reload = 1'b1;
        #2 mrst = 1'b1;
        #1;
        check("R7 async q", q, 0);
        check("R7 async tc_n", tc_n, 1);
        @(posedge clk);
        #1;
        check("R7 override q", q, 0);
        @(negedge clk);
        mrst = 1'b0; load_n = 1'b1; cnt_en_n = 1'b1;
        exp_q = '0;

        // Random mix of load, count and hold
        for (int i = 0; i < 3000; i++) begin
            logic [W-1:0] p;
            logic ld, ce, tl;
            p  = ($urandom % 4 == 0) ? 8'hFD + W'($urandom % 3) : W'($urandom);
            ld = ($urandom % 16) != 0;
            ce = ($urandom % 5) == 0;
            tl = ($urandom % 2) == 1;
            tick(p, ld, ce, tl, "R1/R2/R3/R6 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule